// File: doc/BRIEF.md
# Programmable Memory Test Pattern Streamer

This block keeps a table of test words loaded by a host and plays it out, over and over, on a valid/ready streaming source. A downstream memory writer takes the words and stores them into the memory under test. The host composes the test pattern itself, for example a walking bit, a two-word toggle or a pseudo-random sequence. It writes the words into the table through a write-only port, sets how many entries are in use, and starts the stream. The output steps through the entries and returns to the first one after the last entry in use.

Control and status sit on a separate small register port with its own address range. The control register holds a run bit and a length register. A status register reports whether the stream is running, a sticky flag for table writes that were refused, and the index of the entry currently presented. While the stream is running the table is locked, so a stalled word can never change under the consumer. Reset is asserted asynchronously and must be released synchronously to `clk`.

Top module: `pattern_streamer`

## Requirements
- R1: A table write while the block is idle (run bit clear and stream stopped) stores `tbl_wr_data` at entry `tbl_wr_addr`, and that word is later streamed as that entry.
- R2: Register port map, on `csr_addr`: 0 is control (bit 0 is the run bit), 1 is length (16 bits, reads back exactly what was written), 2 is status. Reads are combinational on `csr_addr`.
- R3: Setting the run bit raises `src_valid` within two cycles, and the first word presented is entry 0.
- R4: The entry index advances only on a cycle where `src_valid` and `src_ready` are both high. While `src_valid` is high and `src_ready` is low, `src_valid` and `src_data` stay unchanged.
- R5: After entry L-1 is accepted, where L is the effective length, the next word presented is entry 0, and this repeats indefinitely.
- R6: A programmed length of 0 is treated as 1, so entry 0 is repeated.
- R7: A programmed length above the table depth (256) is clamped to the depth.
- R8: Clearing the run bit keeps `src_valid` high until the word presented is accepted. `src_valid` then drops and the index returns to 0.
- R9: Status bit 0 equals `src_valid`. Status bits 16 and up hold the index of the entry presented.
- R10: A table write while the run bit is set or the stream is running is ignored and sets sticky status bit 1. Writing status with bit 1 set clears the flag. If a clear and a refused write happen in the same cycle, the set wins.
- R11: After reset, `src_valid` is 0 and the control, length and status registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 8 | Table entry index (log2 of DEPTH) |
| tbl_wr_data | input | 32 | Word to store (DATA_W) |
| csr_wr_en | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select |
| csr_wr_data | input | 16 | Register write data |
| csr_rd_data | output | 32 | Register read data for `csr_addr` |
| src_valid | output | 1 | Stream word valid |
| src_ready | input | 1 | Consumer accepts word |
| src_data | output | 32 | Stream word (DATA_W) |

## Verification
Random ready patterns are run against a bench model of the table to catch an index that moves on a stalled cycle or wraps one entry late. A design with either fault shows a word repeated or skipped against the model. A length of 0 and a length above the depth target the clamp: an unclamped design would stall at a huge count or stream entry 0 and then wander into unwritten entries. Stopping while the consumer stalls checks that `src_valid` is not withdrawn before acceptance and that a restart begins at entry 0. A table write during a run probes the lock: a design that lets the write through corrupts a later stream and leaves the error flag clear.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam int CSR_WW  = 16;
  localparam int CSR_RW  = 32;
  localparam int IDX_LSB = 16;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LEN  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/pat_table.sv
module pat_table #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              lock,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_reject
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic wr_ok;

  assign wr_ok     = wr_en & ~lock;
  assign wr_reject = wr_en & lock;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pat_csr.sv
module pat_csr
  import pat_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [CSR_WW-1:0] wr_data,
  output logic [CSR_RW-1:0] rd_data,
  input  logic              reject,
  input  logic              running,
  input  logic [AW-1:0]     idx,
  output logic              run_en,
  output logic [CSR_WW-1:0] len_raw,
  output logic              err_flag
);
  logic              en_q, en_d;
  logic [CSR_WW-1:0] len_q, len_d;
  logic              err_q, err_d;

  always_comb begin
    en_d  = en_q;
    len_d = len_q;
    err_d = err_q;
    if (wr_en) begin
      case (addr)
        ADDR_CTRL: en_d  = wr_data[0];
        ADDR_LEN:  len_d = wr_data;
        ADDR_STAT: if (wr_data[1]) err_d = 1'b0;
        default: ;
      endcase
    end
    if (reject) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      len_q <= '0;
      err_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      len_q <= len_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_CTRL: rd_data[0] = en_q;
      ADDR_LEN:  rd_data[CSR_WW-1:0] = len_q;
      ADDR_STAT: begin
        rd_data[0] = running;
        rd_data[1] = err_q;
        rd_data[IDX_LSB +: AW] = idx;
      end
      default: ;
    endcase
  end

  assign run_en   = en_q;
  assign len_raw  = len_q;
  assign err_flag = err_q;
endmodule

// File: rtl/pat_reader.sv
module pat_reader
  import pat_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [CSR_WW-1:0] len_raw,
  input  logic              ready,
  output logic              valid,
  output logic [AW-1:0]     ptr,
  output logic [AW:0]       len_eff,
  output logic              lock
);
  localparam logic [CSR_WW-1:0] DEPTH_W = CSR_WW'(DEPTH);

  logic          active_q, active_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          at_last;

  always_comb begin
    if (len_raw == '0)          len_eff = (AW+1)'(1);
    else if (len_raw > DEPTH_W) len_eff = (AW+1)'(DEPTH);
    else                        len_eff = (AW+1)'(len_raw);
  end

  assign at_last = ({1'b0, ptr_q} >= (len_eff - (AW+1)'(1)));

  always_comb begin
    active_d = active_q;
    ptr_d    = ptr_q;
    if (!active_q) begin
      if (run_en) active_d = 1'b1;
    end else if (ready) begin
      if (!run_en) begin
        active_d = 1'b0;
        ptr_d    = '0;
      end else if (at_last) begin
        ptr_d    = '0;
      end else begin
        ptr_d    = ptr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
    end else begin
      active_q <= active_d;
      ptr_q    <= ptr_d;
    end
  end

  assign valid = active_q;
  assign ptr   = ptr_q;
  assign lock  = run_en | active_q;
endmodule

// File: rtl/pattern_streamer.sv
module pattern_streamer
  import pat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic [AW-1:0]     tbl_wr_addr,
  input  logic [DATA_W-1:0] tbl_wr_data,
  input  logic              csr_wr_en,
  input  logic [1:0]        csr_addr,
  input  logic [CSR_WW-1:0] csr_wr_data,
  output logic [CSR_RW-1:0] csr_rd_data,
  output logic              src_valid,
  input  logic              src_ready,
  output logic [DATA_W-1:0] src_data
);
  logic              run_en, tbl_lock, tbl_reject, err_flag;
  logic [CSR_WW-1:0] len_raw;
  logic [AW-1:0]     ptr;
  logic [AW:0]       len_eff;

  pat_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr_en), .addr(csr_addr),
    .wr_data(csr_wr_data), .rd_data(csr_rd_data), .reject(tbl_reject),
    .running(src_valid), .idx(ptr), .run_en(run_en), .len_raw(len_raw),
    .err_flag(err_flag)
  );

  pat_reader #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .len_raw(len_raw),
    .ready(src_ready), .valid(src_valid), .ptr(ptr), .len_eff(len_eff),
    .lock(tbl_lock)
  );

  pat_table #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tbl (
    .clk(clk), .wr_en(tbl_wr_en), .lock(tbl_lock), .wr_addr(tbl_wr_addr),
    .wr_data(tbl_wr_data), .rd_addr(ptr), .rd_data(src_data),
    .wr_reject(tbl_reject)
  );
endmodule

// File: rtl/pattern_streamer_chk.sv
module pattern_streamer_chk #(
  parameter int DATA_W = 32,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_valid,
  input logic              src_ready,
  input logic [DATA_W-1:0] src_data,
  input logic              tbl_wr_en,
  input logic              tbl_lock,
  input logic              err_flag,
  input logic              run_en,
  input logic [AW-1:0]     ptr,
  input logic [AW:0]       len_eff
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && !src_ready |=> src_valid && $stable(src_data) && $stable(ptr));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && run_en && ({1'b0, ptr} < len_eff - 1'b1)
    |=> ptr == $past(ptr) + 1'b1);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && run_en && ({1'b0, ptr} == len_eff - 1'b1)
    |=> ptr == '0);

  p_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_valid) |-> ptr == '0);

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && !run_en |=> !src_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |-> ptr == '0);

  p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en && tbl_lock |=> err_flag);
endmodule

bind pattern_streamer pattern_streamer_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .src_data(src_data), .tbl_wr_en(tbl_wr_en), .tbl_lock(tbl_lock),
  .err_flag(err_flag), .run_en(run_en), .ptr(ptr), .len_eff(len_eff)
);

// File: tb/sim_pattern_streamer.sv
module sim_pattern_streamer;
  localparam int DW = 32;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic tbl_wr_en;
  logic [AW-1:0] tbl_wr_addr;
  logic [DW-1:0] tbl_wr_data;
  logic csr_wr_en;
  logic [1:0] csr_addr;
  logic [15:0] csr_wr_data;
  logic [31:0] csr_rd_data;
  logic src_valid, src_ready;
  logic [DW-1:0] src_data;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];
  int eidx;

  always #10 clk = ~clk;

  pattern_streamer u0 (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_data(tbl_wr_data), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
    .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int raw);
    if (raw == 0) return 1;
    if (raw > DEPTH) return DEPTH;
    return raw;
  endfunction

  task automatic csr_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_addr = a; csr_wr_data = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rd_data;
  endtask

  task automatic tbl_wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = AW'(a); tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // Start a run with the given raw length, then stream n accepted words.
  task automatic run(input int len_raw, input int n, input int pct, input string req);
    int len, fires, guard;
    len = eff_len(len_raw);
    src_ready = 1'b0;
    csr_wr(2'd1, 16'(len_raw));
    csr_wr(2'd0, 16'h1);
    guard = 0;
    while (!src_valid && guard < 4) begin @(negedge clk); guard++; end
    chk(src_valid === 1'b1, "R3", "valid after run bit", 64'(src_valid), 64'd1);
    chk(src_data === model[0], "R3", "first word is entry 0", 64'(src_data), 64'(model[0]));
    eidx = 0; fires = 0;
    while (fires < n) begin
      bit rdy;
      rdy = ($urandom_range(99) < pct);
      chk(src_valid === 1'b1 && src_data === model[eidx], req, "stream word",
          64'(src_data), 64'(model[eidx]));
      src_ready = rdy;
      @(posedge clk);
      if (rdy) begin eidx = (eidx + 1) % len; fires++; end
      @(negedge clk);
    end
    src_ready = 1'b0;
  endtask

  task automatic stop_run();
    logic [31:0] st;
    src_ready = 1'b0;
    csr_wr(2'd0, 16'h0);
    chk(src_valid === 1'b1, "R8", "valid held until accepted", 64'(src_valid), 64'd1);
    chk(src_data === model[eidx], "R8", "held word", 64'(src_data), 64'(model[eidx]));
    src_ready = 1'b1;
    @(negedge clk);
    src_ready = 1'b0;
    chk(src_valid === 1'b0, "R8", "valid low after last accept", 64'(src_valid), 64'd0);
    csr_rd(2'd2, st);
    chk(st[0] == 1'b0 && st[23:16] == 8'd0, "R8", "idle status index 0",
        64'(st), 64'(st[1]) << 1);
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_addr = '0; tbl_wr_data = '0;
    csr_wr_en = 1'b0; csr_addr = '0; csr_wr_data = '0; src_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(src_valid === 1'b0, "R11", "valid after reset", 64'(src_valid), 64'd0);
    csr_rd(2'd0, rd); chk(rd === 32'd0, "R11", "control reset", 64'(rd), 64'd0);
    csr_rd(2'd1, rd); chk(rd === 32'd0, "R11", "length reset", 64'(rd), 64'd0);
    csr_rd(2'd2, rd); chk(rd === 32'd0, "R11", "status reset", 64'(rd), 64'd0);

    // R2 length read-back
    csr_wr(2'd1, 16'hA5C3);
    csr_rd(2'd1, rd); chk(rd === 32'h0000A5C3, "R2", "length readback", 64'(rd), 64'hA5C3);

    // R1, R5 walking ones over 32 entries
    for (int i = 0; i < 32; i++) begin
      model[i] = DW'(1) << i;
      tbl_wr(i, model[i]);
    end
    run(32, 80, 100, "R5");
    // R4, R9 stall with ready low
    csr_rd(2'd2, rd);
    chk(rd[0] == 1'b1 && rd[23:16] == 8'(eidx), "R9", "status running and index",
        64'(rd), (64'(eidx) << 16) | 64'd1);
    repeat (3) @(negedge clk);
    chk(src_valid === 1'b1 && src_data === model[eidx], "R4", "stable while stalled",
        64'(src_data), 64'(model[eidx]));
    csr_rd(2'd2, rd);
    chk(rd[23:16] == 8'(eidx), "R4", "index unchanged while stalled", 64'(rd[23:16]), 64'(eidx));
    stop_run();

    // R1 walking zeros reloads the table while idle
    for (int i = 0; i < 32; i++) begin
      model[i] = ~(DW'(1) << i);
      tbl_wr(i, model[i]);
    end
    run(32, 40, 50, "R1");
    stop_run();

    // R5 two-entry toggle with random ready
    model[0] = 32'h0000FFFF; tbl_wr(0, model[0]);
    model[1] = 32'hFFFF0000; tbl_wr(1, model[1]);
    run(2, 20, 60, "R5");
    stop_run();

    // R6 length 0 repeats entry 0
    run(0, 8, 70, "R6");
    stop_run();

    // R7 length clamped to depth
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = $urandom;
      tbl_wr(i, model[i]);
    end
    run(300, 600, 70, "R7");

    // R10 refused write while running
    tbl_wr(5, ~model[5]);
    csr_rd(2'd2, rd); chk(rd[1] === 1'b1, "R10", "sticky error set", 64'(rd[1]), 64'd1);
    stop_run();
    csr_rd(2'd2, rd); chk(rd[1] === 1'b1, "R10", "error stays after stop", 64'(rd[1]), 64'd1);
    run(8, 12, 100, "R10");
    stop_run();
    csr_wr(2'd2, 16'h2);
    csr_rd(2'd2, rd); chk(rd[1] === 1'b0, "R10", "error cleared", 64'(rd[1]), 64'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule